// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block predicts whether a conditional branch will be taken. It combines a short record of recent branch outcomes with low address bits of the branch. A global shift register holds the outcomes of the most recent resolved branches. That history value chooses one of several pattern tables. Within the chosen table, the low bits of the branch address pick one saturating counter, and the top bit of that counter is the prediction.

The fetch side presents a branch address and receives a direction at once, from a combinational read. The block also returns the history value that formed the index, so the pipeline can carry it along with the branch. When the branch resolves, the pipeline presents the same address, the carried history and the real outcome. The counter that made the prediction is then trained, and the outcome is shifted into the global history.

The history depth, the number of address bits and the counter width are all parameters. With a history depth of zero the block becomes a plain table of counters indexed by address alone.

Top module: `gap_dir_predictor`

## Requirements
- R1: After reset the history reads zero and every counter holds the weakly-not-taken value 2^(n-1)-1, so every address predicts not taken (0).
- R2: The prediction is the top bit of the counter at index {history, pred_pc[N-1:0]}, with 1 meaning taken; address bits at and above N have no effect.
- R3: A resolve with res_taken=1 adds one to the selected counter and holds it at 2^n-1 once it is there.
- R4: A resolve with res_taken=0 subtracts one from the selected counter and holds it at 0 once it is there.
- R5: Each resolve shifts res_taken into bit 0 of the history, moves every bit up one place and discards the oldest bit. pred_hist shows this from the next cycle.
- R6: A resolve trains the counter chosen by res_hist together with res_pc, not by the current history register.
- R7: Each history value selects its own table. Training one address under one history leaves that address unchanged under every other history value.
- R8: While res_valid is 0, neither the counters nor the history change, whatever res_pc, res_hist and res_taken carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_W,1) | History value used to form the prediction index |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_hist | input | max(HIST_W,1) | History captured when that branch was predicted |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A counter that steps the wrong way, or fails to saturate, stays hidden until the same table entry is predicted again. It then shows as a flipped direction after one or two further outcomes, so the tests push counters past both ends and watch the crossing point of the top bit. A history register that shifts wrongly shows on pred_hist in the cycle right after the resolve. It also moves predictions into the wrong table, which the tests catch by reading one address under every history value. A missing enable shows as drift of pred_hist and of a trained entry while res_valid is low.

// File: rtl/gap_pkg.sv
package gap_pkg;

   localparam int GAP_CTR_W_MAX = 8;

   typedef enum logic {
      DIR_NOT_TAKEN = 1'b0,
      DIR_TAKEN     = 1'b1
   } gap_dir_e;

   // One saturating step of a direction counter, held at 0 and at top.
   function automatic logic [GAP_CTR_W_MAX-1:0] gap_sat_step(
      input logic [GAP_CTR_W_MAX-1:0] cur,
      input logic [GAP_CTR_W_MAX-1:0] top,
      input logic                     up
   );
      logic [GAP_CTR_W_MAX-1:0] res;
      if (up) res = (cur == top) ? cur : cur + 1'b1;
      else    res = (cur == '0)  ? cur : cur - 1'b1;
      return res;
   endfunction

endpackage

// File: rtl/gap_history.sv
module gap_history #(
   parameter int HIST_W = 2,
   parameter int HOUT_W = (HIST_W > 0) ? HIST_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HOUT_W-1:0] hist_q
);

   generate
      if (HIST_W == 0) begin : g_none
         logic unused_shift;
         assign unused_shift = shift_en ^ shift_bit ^ clk ^ rst_n;
         assign hist_q = '0;
      end else if (HIST_W == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= shift_bit;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
         end
      end
   endgenerate

endmodule

// File: rtl/gap_index_former.sv
module gap_index_former #(
   parameter int PC_W      = 32,
   parameter int HIST_W    = 2,
   parameter int ADDR_BITS = 4,
   parameter int HOUT_W    = (HIST_W > 0) ? HIST_W : 1,
   parameter int IDX_W     = HIST_W + ADDR_BITS
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HOUT_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);

   generate
      if (HIST_W == 0) begin : g_addr_only
         logic unused_hist;
         assign unused_hist = ^hist;
         assign idx = pc[ADDR_BITS-1:0];
      end else begin : g_hist_addr
         assign idx = {hist[HIST_W-1:0], pc[ADDR_BITS-1:0]};
      end

      if (PC_W > ADDR_BITS) begin : g_pc_hi
         logic unused_pc_hi;
         assign unused_pc_hi = ^pc[PC_W-1:ADDR_BITS];
      end
   endgenerate

endmodule

// File: rtl/gap_counter_bank.sv
module gap_counter_bank
   import gap_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_taken,
   output logic [CTR_W-1:0] upd_ctr
);

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_TOP  = '1;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] ctr_nxt;

   assign rd_ctr  = ctr_q[rd_idx];
   assign upd_ctr = ctr_q[upd_idx];
   assign ctr_nxt = CTR_W'(gap_sat_step(GAP_CTR_W_MAX'(upd_ctr),
                                        GAP_CTR_W_MAX'(CTR_TOP),
                                        upd_taken));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_INIT;
      end else if (upd_en) begin
         ctr_q[upd_idx] <= ctr_nxt;
      end
   end

endmodule

// File: rtl/gap_dir_predictor.sv
module gap_dir_predictor
   import gap_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int HIST_W    = 2,
   parameter int ADDR_BITS = 4,
   parameter int CTR_W     = 2,
   parameter int HOUT_W    = (HIST_W > 0) ? HIST_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   pred_pc,
   output logic              pred_taken,
   output logic [HOUT_W-1:0] pred_hist,
   input  logic              res_valid,
   input  logic [PC_W-1:0]   res_pc,
   input  logic [HOUT_W-1:0] res_hist,
   input  logic              res_taken
);

   localparam int IDX_W = HIST_W + ADDR_BITS;

   generate
      if (ADDR_BITS < 1 || ADDR_BITS > PC_W) begin : g_bad_addr
         $error("gap_dir_predictor: ADDR_BITS must lie in 1..PC_W");
      end
      if (CTR_W < 1 || CTR_W > GAP_CTR_W_MAX) begin : g_bad_ctr
         $error("gap_dir_predictor: CTR_W out of range");
      end
      if (HIST_W < 0 || IDX_W > 16) begin : g_bad_hist
         $error("gap_dir_predictor: table index too wide");
      end
   endgenerate

   logic [HOUT_W-1:0] hist_q;
   logic [IDX_W-1:0]  pred_idx;
   logic [IDX_W-1:0]  res_idx;
   logic [CTR_W-1:0]  pred_ctr;
   logic [CTR_W-1:0]  res_ctr;

   gap_history #(.HIST_W(HIST_W), .HOUT_W(HOUT_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .shift_en(res_valid), .shift_bit(res_taken),
      .hist_q(hist_q)
   );

   gap_index_former #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS),
                      .HOUT_W(HOUT_W), .IDX_W(IDX_W)) u_pidx (
      .pc(pred_pc), .hist(hist_q), .idx(pred_idx)
   );

   gap_index_former #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS),
                      .HOUT_W(HOUT_W), .IDX_W(IDX_W)) u_ridx (
      .pc(res_pc), .hist(res_hist), .idx(res_idx)
   );

   gap_counter_bank #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pred_idx), .rd_ctr(pred_ctr),
      .upd_en(res_valid), .upd_idx(res_idx), .upd_taken(res_taken),
      .upd_ctr(res_ctr)
   );

   assign pred_taken = pred_ctr[CTR_W-1];
   assign pred_hist  = hist_q;

endmodule

// File: rtl/gap_dir_predictor_chk.sv
module gap_dir_predictor_chk #(
   parameter int HIST_W = 2,
   parameter int IDX_W  = 6,
   parameter int CTR_W  = 2,
   parameter int HOUT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pred_taken,
   input logic [HOUT_W-1:0] pred_hist,
   input logic              res_valid,
   input logic              res_taken,
   input logic [IDX_W-1:0]  pred_idx,
   input logic [IDX_W-1:0]  res_idx,
   input logic [CTR_W-1:0]  res_ctr
);

   localparam logic [CTR_W-1:0] CTOP = '1;

   // R2: prediction port agrees with the training port's view of one entry
   assert_pred_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_idx == res_idx) |-> (pred_taken == res_ctr[CTR_W-1]));

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && res_taken && (res_ctr != CTOP)) && $stable(res_idx))
      |-> (res_ctr == $past(res_ctr) + CTR_W'(1)));

   assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && res_taken && (res_ctr == CTOP)) && $stable(res_idx))
      |-> (res_ctr == CTOP));

   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && !res_taken && (res_ctr != '0)) && $stable(res_idx))
      |-> (res_ctr == $past(res_ctr) - CTR_W'(1)));

   assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && !res_taken && (res_ctr == '0)) && $stable(res_idx))
      |-> (res_ctr == '0));

   assert_ctr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!res_valid) && $stable(res_idx)) |-> $stable(res_ctr));

   generate
      if (HIST_W > 0) begin : g_hist_chk
         assert_hist_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (pred_hist == '0));

         assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |=> (pred_hist == HOUT_W'({$past(pred_hist), $past(res_taken)})));

         assert_hist_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !res_valid |=> $stable(pred_hist));
      end
   endgenerate

endmodule

bind gap_dir_predictor gap_dir_predictor_chk #(
   .HIST_W(HIST_W), .IDX_W(IDX_W), .CTR_W(CTR_W), .HOUT_W(HOUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pred_taken(pred_taken), .pred_hist(pred_hist),
   .res_valid(res_valid), .res_taken(res_taken), .pred_idx(pred_idx),
   .res_idx(res_idx), .res_ctr(res_ctr)
);

// File: tb/gap_dir_predictor_test.sv
module gap_dir_predictor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic [1:0]  pred_hist;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic [1:0]  res_hist = '0;
   logic        res_taken = 1'b0;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   logic [1:0] mctr [64];
   logic [1:0] mhist;

   always #2 clk = ~clk;

   gap_dir_predictor #(.PC_W(32), .HIST_W(2), .ADDR_BITS(4), .CTR_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
      .res_hist(res_hist), .res_taken(res_taken)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_resolve(input logic [31:0] pc, input logic [1:0] h, input logic t);
      @(negedge clk);
      res_pc = pc; res_hist = h; res_taken = t; res_valid = 1'b1;
      @(posedge clk);
      if (t) mctr[{h, pc[3:0]}] = (mctr[{h, pc[3:0]}] == 2'd3) ? 2'd3 : mctr[{h, pc[3:0]}] + 2'd1;
      else   mctr[{h, pc[3:0]}] = (mctr[{h, pc[3:0]}] == 2'd0) ? 2'd0 : mctr[{h, pc[3:0]}] - 2'd1;
      mhist = {mhist[0], t};
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   // Drives the history to h through a scratch entry (pc 15, table 3).
   task automatic set_hist(input logic [1:0] h);
      do_resolve(32'hF, 2'd3, h[1]);
      do_resolve(32'hF, 2'd3, h[0]);
   endtask

   task automatic check_pred(input string req, input logic [31:0] pc, input logic exp);
      @(negedge clk);
      pred_pc = pc;
      #1;
      chk(req, {31'd0, pred_taken}, {31'd0, exp});
      chk({req, " model"}, {31'd0, pred_taken}, {31'd0, mctr[{mhist, pc[3:0]}][1]});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 64; i++) mctr[i] = 2'b01;
      mhist = 2'b00;
      #1;
      chk("R1 history", {30'd0, pred_hist}, 32'd0);
      for (int p = 0; p < 16; p++) check_pred("R1 reset predict", p, 1'b0);
   endtask

   task automatic t_saturate_up;
      for (int i = 0; i < 5; i++) do_resolve(32'h5, 2'd0, 1'b1);
      set_hist(2'd0);
      check_pred("R3 trained taken", 32'h5, 1'b1);
      do_resolve(32'h5, 2'd0, 1'b0);
      set_hist(2'd0);
      check_pred("R3 held at top", 32'h5, 1'b1);
      do_resolve(32'h5, 2'd0, 1'b0);
      set_hist(2'd0);
      check_pred("R3 second drop", 32'h5, 1'b0);
   endtask

   task automatic t_saturate_down;
      for (int i = 0; i < 5; i++) do_resolve(32'h6, 2'd1, 1'b0);
      set_hist(2'd1);
      check_pred("R4 trained not taken", 32'h6, 1'b0);
      do_resolve(32'h6, 2'd1, 1'b1);
      set_hist(2'd1);
      check_pred("R4 held at zero", 32'h6, 1'b0);
      do_resolve(32'h6, 2'd1, 1'b1);
      set_hist(2'd1);
      check_pred("R4 second rise", 32'h6, 1'b1);
   endtask

   task automatic t_history;
      do_resolve(32'hF, 2'd3, 1'b1);
      chk("R5 shift one", {30'd0, pred_hist}, {30'd0, mhist});
      do_resolve(32'hF, 2'd3, 1'b0);
      chk("R5 shift taken then not", {30'd0, pred_hist}, 32'd2);
      do_resolve(32'hF, 2'd3, 1'b1);
      chk("R5 oldest dropped", {30'd0, pred_hist}, 32'd1);
   endtask

   task automatic t_tables;
      set_hist(2'd2);
      do_resolve(32'h9, 2'd1, 1'b1);
      do_resolve(32'h9, 2'd1, 1'b1);
      set_hist(2'd1);
      check_pred("R6 trained via res_hist", 32'h9, 1'b1);
      set_hist(2'd2);
      check_pred("R7 table 2 untouched", 32'h9, 1'b0);
      set_hist(2'd0);
      check_pred("R7 table 0 untouched", 32'h9, 1'b0);
      set_hist(2'd3);
      check_pred("R7 table 3 untouched", 32'h9, 1'b0);
   endtask

   task automatic t_upper_pc;
      set_hist(2'd1);
      check_pred("R2 high bits ignored", 32'h1234_5679, 1'b1);
      check_pred("R2 all high bits set", 32'hFFFF_FFF9, 1'b1);
      check_pred("R2 neighbour entry", 32'h1234_5678, 1'b0);
   endtask

   task automatic t_idle;
      set_hist(2'd1);
      @(negedge clk);
      res_pc = 32'h9; res_hist = 2'd1; res_taken = 1'b0; res_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 history held", {30'd0, pred_hist}, 32'd1);
      check_pred("R8 counter held", 32'h9, 1'b1);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset();
      t_saturate_up();
      t_saturate_down();
      t_history();
      t_tables();
      t_upper_pc();
      t_idle();
      done = 1;
      summary();
      $finish;
   end

endmodule